// File: doc/BRIEF.md
# Interrupt Vector Generator with Autovectoring

This block collects interrupt requests from a set of peripheral sources and produces the vector number the processor needs when it acknowledges an interrupt. Each source has a small control register that sets its interrupt level (1 to 7, with 0 meaning disabled), a priority within that level, and an autovector enable. Every cycle the block reports the highest level among the sources that are currently requesting, so the processor can decide when to start an acknowledge cycle.

When the acknowledge strobe arrives with a level, the block picks one winner among the requesting sources at that level. A higher priority wins, and on equal priority the lower source index wins. If the winner has autovectoring enabled, the vector the source supplies is thrown away and the block returns 24 plus the level. Otherwise the source's own 8-bit vector passes through unchanged. If nothing is pending at the acknowledged level, the block returns the spurious vector 24. The result is registered and flagged valid for exactly one cycle.

Top module: `irq_vector_gen`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_data` into the control register of source `cfg_idx` on the rising clock edge. The field layout is bits [5:3] = level, bits [2:1] = priority and bit [0] = autovector enable. After reset every control register is zero, so every source is disabled.
- R2: `pend_lvl` shows, in the same cycle, the highest level among sources whose `src_req` bit is high and whose level is nonzero. It shows 0 when there is no such source.
- R3: A source configured at level 0 never counts as pending and never wins an acknowledge, even while its request is high.
- R4: Among the pending sources at the acknowledged level, the one with the numerically highest priority wins. On equal priority the lowest source index wins.
- R5: When the winner's autovector bit is 0, `vec_out` equals that source's 8-bit slice of `src_vec` (source i occupies bits [8i+7:8i]), unchanged.
- R6: When the winner's autovector bit is 1, `vec_out` equals 24 plus the acknowledged level (25 to 31 for levels 1 to 7), whatever value the source presents on `src_vec`.
- R7: When no source is pending at the acknowledged level, including an acknowledge at level 0, `vec_out` equals 24 and `vec_valid` is still asserted.
- R8: `vec_valid` is high for exactly the one cycle after the cycle in which `ack_stb` is high. `vec_out` changes only on that edge and holds its value otherwise.
- R9: While reset is asserted and right after it, `vec_valid` is 0, `vec_out` is 0 and `pend_lvl` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write enable |
| cfg_idx | input | IDX_W | Source whose control register is written |
| cfg_data | input | 6 | Control value: level, priority, autovector enable |
| src_req | input | NUM_SRC | Request line per source, held high while pending |
| src_vec | input | NUM_SRC*VEC_W | Vector supplied by each source |
| ack_stb | input | 1 | Acknowledge cycle strobe, one cycle |
| ack_lvl | input | 3 | Level being acknowledged |
| pend_lvl | output | 3 | Highest pending level, 0 if none |
| vec_out | output | VEC_W | Vector number for the acknowledge |
| vec_valid | output | 1 | Vector valid, one cycle after the strobe |

## Verification
The assertions assume that requests and source vectors stay steady across the edge that samples an acknowledge, and that `ack_stb` is a single-cycle pulse. They also assume configuration writes do not coincide with the acknowledge that depends on them. The bench changes every input only on the falling edge. It holds requests through each acknowledge and makes all configuration writes complete before it raises the strobe. It also acknowledges levels above and below the pending level, so that the spurious path and the valid-pulse properties are exercised against the actual request pattern.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   localparam int LVL_W = 3;
   localparam int PRI_W = 2;

   // Control register layout: [5:3] level, [2:1] priority, [0] autovector enable
   typedef struct packed {
      logic [LVL_W-1:0] lvl;
      logic [PRI_W-1:0] pri;
      logic             autovec;
   } src_cfg_t;

   localparam int CFG_W = $bits(src_cfg_t);

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC = 8,
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          idx,
   input  src_cfg_t                  wdata,
   output src_cfg_t [NUM_SRC-1:0]    cfg
);

   // One register per source, each decoding its own write select
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic sel;
      assign sel = we && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg[g] <= '0;
         end else if (sel) begin
            cfg[g] <= wdata;
         end
      end
   end

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC = 8
) (
   input  logic [NUM_SRC-1:0]     req,
   input  src_cfg_t [NUM_SRC-1:0] cfg,
   output logic [NUM_SRC-1:0]     pend,
   output logic [LVL_W-1:0]       max_lvl
);

   // A source is pending only if requesting and enabled (nonzero level)
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
      assign pend[g] = req[g] && (cfg[g].lvl != '0);
   end

   always_comb begin
      max_lvl = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend[i] && (cfg[i].lvl > max_lvl)) begin
            max_lvl = cfg[i].lvl;
         end
      end
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC = 8,
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]     pend,
   input  src_cfg_t [NUM_SRC-1:0] cfg,
   input  logic [LVL_W-1:0]       lvl,
   output logic                   found,
   output logic [IDX_W-1:0]       win_idx,
   output logic                   win_autovec
);

   logic [PRI_W-1:0] best_pri;

   // Scan from the top index down; ">=" lets a lower index take over on a tie
   always_comb begin
      found       = 1'b0;
      win_idx     = '0;
      win_autovec = 1'b0;
      best_pri    = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i] && (cfg[i].lvl == lvl) && (!found || (cfg[i].pri >= best_pri))) begin
            found       = 1'b1;
            win_idx     = IDX_W'(i);
            win_autovec = cfg[i].autovec;
            best_pri    = cfg[i].pri;
         end
      end
   end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int VEC_W        = 8,
   parameter int AUTOVEC_BASE = 24,
   parameter int SPURIOUS_VEC = 24,
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [IDX_W-1:0]           cfg_idx,
   input  logic [CFG_W-1:0]           cfg_data,
   input  logic [NUM_SRC-1:0]         src_req,
   input  logic [NUM_SRC*VEC_W-1:0]   src_vec,
   input  logic                       ack_stb,
   input  logic [LVL_W-1:0]           ack_lvl,
   output logic [LVL_W-1:0]           pend_lvl,
   output logic [VEC_W-1:0]           vec_out,
   output logic                       vec_valid
);

   localparam int MAX_LVL = (1 << LVL_W) - 1;

   // Elaboration-time parameter checks
   if (NUM_SRC < 1) begin : g_chk_src
      $error("irq_vector_gen: NUM_SRC must be at least 1");
   end
   if (AUTOVEC_BASE + MAX_LVL >= (1 << VEC_W)) begin : g_chk_av
      $error("irq_vector_gen: autovector range exceeds VEC_W");
   end
   if (SPURIOUS_VEC >= (1 << VEC_W)) begin : g_chk_sp
      $error("irq_vector_gen: spurious vector exceeds VEC_W");
   end

   src_cfg_t [NUM_SRC-1:0] cfg;
   logic [NUM_SRC-1:0]     pend;
   logic                   found;
   logic [IDX_W-1:0]       win_idx;
   logic                   win_autovec;
   logic [VEC_W-1:0]       next_vec;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .idx   (cfg_idx),
      .wdata (src_cfg_t'(cfg_data)),
      .cfg   (cfg)
   );

   irq_level_scan #(.NUM_SRC(NUM_SRC)) u_scan (
      .req     (src_req),
      .cfg     (cfg),
      .pend    (pend),
      .max_lvl (pend_lvl)
   );

   irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .pend        (pend),
      .cfg         (cfg),
      .lvl         (ack_lvl),
      .found       (found),
      .win_idx     (win_idx),
      .win_autovec (win_autovec)
   );

   // Vector selection: spurious, computed from level, or source supplied
   always_comb begin
      if (!found) begin
         next_vec = VEC_W'(SPURIOUS_VEC);
      end else if (win_autovec) begin
         next_vec = VEC_W'(AUTOVEC_BASE) + VEC_W'(ack_lvl);
      end else begin
         next_vec = src_vec[win_idx*VEC_W +: VEC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= ack_stb;
         if (ack_stb) begin
            vec_out <= next_vec;
         end
      end
   end

endmodule

// File: rtl/irq_vector_gen_chk.sv
module irq_vector_gen_chk #(
   parameter int NUM_SRC      = 8,
   parameter int VEC_W        = 8,
   parameter int SPURIOUS_VEC = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic               ack_stb,
   input logic [2:0]         ack_lvl,
   input logic [2:0]         pend_lvl,
   input logic [VEC_W-1:0]   vec_out,
   input logic               vec_valid
);

   p_valid_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> vec_valid);

   p_no_valid_without_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> !vec_valid);

   p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> $stable(vec_out));

   p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req == '0) |-> (pend_lvl == 3'd0));

   p_spurious_lvl0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && ack_lvl == 3'd0) |=> (vec_out == VEC_W'(SPURIOUS_VEC)));

   p_spurious_above_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && ack_lvl > pend_lvl) |=> (vec_out == VEC_W'(SPURIOUS_VEC)));

endmodule

bind irq_vector_gen irq_vector_gen_chk #(
   .NUM_SRC      (NUM_SRC),
   .VEC_W        (VEC_W),
   .SPURIOUS_VEC (SPURIOUS_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_req   (src_req),
   .ack_stb   (ack_stb),
   .ack_lvl   (ack_lvl),
   .pend_lvl  (pend_lvl),
   .vec_out   (vec_out),
   .vec_valid (vec_valid)
);

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb;

   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam int VW    = 8;
   localparam int IW    = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [IW-1:0]   cfg_idx = '0;
   logic [5:0]      cfg_data = '0;
   logic [N-1:0]    src_req = '0;
   logic [N*VW-1:0] src_vec = '0;
   logic            ack_stb = 1'b0;
   logic [2:0]      ack_lvl = '0;
   logic [2:0]      pend_lvl;
   logic [VW-1:0]   vec_out;
   logic            vec_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   irq_vector_gen #(.NUM_SRC(N), .VEC_W(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .src_req(src_req), .src_vec(src_vec),
      .ack_stb(ack_stb), .ack_lvl(ack_lvl), .pend_lvl(pend_lvl),
      .vec_out(vec_out), .vec_valid(vec_valid)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input int idx, input int lvl, input int pri, input int av);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_idx  = IW'(idx);
      cfg_data = {3'(lvl), 2'(pri), 1'(av)};
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   task automatic clear_all();
      src_req = '0;
      for (int i = 0; i < N; i++) wr_cfg(i, 0, 0, 0);
   endtask

   // Strobe one acknowledge, check the one-cycle valid pulse and the vector
   task automatic ack_check(input string tag, input int lvl, input int exp);
      @(negedge clk);
      ack_stb = 1'b1;
      ack_lvl = 3'(lvl);
      @(negedge clk);
      ack_stb = 1'b0;
      chk({tag, " R8 valid"}, int'(vec_valid), 1);
      chk(tag, int'(vec_out), exp);
      @(negedge clk);
      chk({tag, " R8 valid drop"}, int'(vec_valid), 0);
      chk({tag, " R8 hold"}, int'(vec_out), exp);
   endtask

   task automatic t_reset();
      chk("R9 valid", int'(vec_valid), 0);
      chk("R9 vec", int'(vec_out), 0);
      chk("R9 pend", int'(pend_lvl), 0);
      @(negedge clk);
      src_req = '1;
      #1 chk("R1 reset cfg disables all", int'(pend_lvl), 0);
      src_req = '0;
   endtask

   task automatic t_pend_level();
      clear_all();
      wr_cfg(0, 2, 0, 0);
      wr_cfg(3, 5, 0, 0);
      wr_cfg(6, 4, 0, 0);
      @(negedge clk); src_req = 8'b0000_0001;
      #1 chk("R2 one source", int'(pend_lvl), 2);
      @(negedge clk); src_req = 8'b0100_0001;
      #1 chk("R2 two sources", int'(pend_lvl), 4);
      @(negedge clk); src_req = 8'b0100_1001;
      #1 chk("R2 three sources", int'(pend_lvl), 5);
      @(negedge clk); src_req = 8'b0000_1000;
      #1 chk("R1 written level", int'(pend_lvl), 5);
   endtask

   task automatic t_level0();
      clear_all();
      wr_cfg(2, 3, 3, 0);
      wr_cfg(2, 0, 3, 0);
      wr_cfg(5, 1, 0, 0);
      @(negedge clk); src_req = 8'b0010_0100;
      #1 chk("R3 level0 not pending", int'(pend_lvl), 1);
      ack_check("R3 level0 never wins", 0, 24);
   endtask

   task automatic t_priority();
      clear_all();
      for (int i = 0; i < N; i++) src_vec[i*VW +: VW] = VW'(8'h40 + i);
      wr_cfg(1, 3, 1, 0);
      wr_cfg(2, 3, 3, 0);
      wr_cfg(5, 3, 2, 0);
      wr_cfg(0, 6, 3, 0);
      @(negedge clk); src_req = 8'b0010_0111;
      ack_check("R4 R5 highest priority", 3, 8'h42);
      src_req = 8'b0010_0011;
      ack_check("R4 R5 next priority", 3, 8'h45);
   endtask

   task automatic t_tie();
      clear_all();
      wr_cfg(7, 6, 2, 0);
      wr_cfg(4, 6, 2, 0);
      wr_cfg(6, 6, 1, 0);
      @(negedge clk); src_req = 8'b1101_0000;
      ack_check("R4 tie lowest index", 6, 8'h44);
   endtask

   task automatic t_autovec();
      clear_all();
      wr_cfg(4, 6, 2, 1);
      wr_cfg(7, 7, 0, 1);
      wr_cfg(1, 1, 0, 1);
      @(negedge clk); src_req = 8'b1001_0010;
      ack_check("R6 level 6", 6, 30);
      src_vec[4*VW +: VW] = 8'hA5;
      ack_check("R6 source vector ignored", 6, 30);
      ack_check("R6 level 7", 7, 31);
      ack_check("R6 level 1", 1, 25);
   endtask

   task automatic t_spurious();
      clear_all();
      wr_cfg(3, 4, 0, 0);
      @(negedge clk); src_req = 8'b0000_1000;
      ack_check("R7 empty level", 2, 24);
      ack_check("R7 level 0", 0, 24);
      src_req = '0;
      ack_check("R7 request dropped", 4, 24);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pend_level();
      t_level0();
      t_priority();
      t_tie();
      t_autovec();
      t_spurious();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule